// File: doc/BRIEF.md
# Dual-Scale Watchdog with Reset Generation

This block is a watchdog timer whose timeout register holds a 5-bit count. A one-bit base select picks one of two units: a short one or a long one. Each unit is a parameter counted in clock cycles. A prescaler divides the clock down to one tick per unit, and a down-counter expires after (n+1) ticks, where n is the programmed field. When the counter expires, a sticky timeout status flag is set. If the watchdog reset enable is on, a fixed-length reset pulse is also issued.

Software arms and services the watchdog in the same way. Writing the timeout register, or pulsing the kick strobe, raises the `reload` input. This reloads the count, restarts the prescaler and latches the base select. The counter does not run again after it expires until the next reload.

The block has a second reset source. A rising edge on the frequency-change event input produces the same reset pulse, under its own enable bit. With the base select at 0 the unit stands for 150 ms, giving timeouts from 150 ms to 4.8 s. With the base select at 1 the unit stands for 2.5 s, giving timeouts from 2.5 s to 80 s. In both cases the unit is scaled to the `SHORT_CYC` and `LONG_CYC` cycle counts.

Top module: `wdg_top`

## Requirements
- R1: After reset, `sts_timeout` and `rst_pulse` are 0 and the counter is idle. No timeout occurs before the first `reload`.
- R2: Let the clock edge that samples `reload` high be edge E. With timeout field n, `sts_timeout` rises at edge E + (n+1)·U. U is `SHORT_CYC` when `cfg_long_base` is 0 and `LONG_CYC` when it is 1. Field value 0 therefore means 1 unit, and 31 means 32 units.
- R3: On expiry the counter stops at zero and does not wrap. Without a new `reload` there is no further expiry and no further watchdog pulse.
- R4: `sts_timeout` stays at 1 until an edge samples `sts_clr` high, and it reads 0 after that edge. If expiry and clear fall on the same edge, the status is set.
- R5: A watchdog expiry starts a reset pulse, at the same edge that sets the status, only if `cfg_wd_rst_en` is 1 at that edge. If the enable is 0, no pulse results.
- R6: Each reset pulse is high for exactly `RST_PULSE_CYC` consecutive cycles. A trigger that arrives while a pulse is high neither extends nor restarts it.
- R7: Let edge E be the first edge that samples `freq_evt` high after a low sample. If `cfg_fc_rst_en` is 1, `rst_pulse` rises at edge E+1. Holding `freq_evt` high gives no further pulse. With the enable at 0, no pulse results.
- R8: A `reload` during a count restarts the full period, prescaler included, from the reload edge.
- R9: `cfg_long_base` is sampled only at `reload`. Changing it during a count does not change the running timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timeout | input | 5 | Timeout field n; period is n+1 units |
| cfg_long_base | input | 1 | Base select: 0 = short unit, 1 = long unit |
| cfg_wd_rst_en | input | 1 | Enable reset pulse on watchdog expiry |
| cfg_fc_rst_en | input | 1 | Enable reset pulse on frequency-change event |
| reload | input | 1 | Register write or kick: reload count, restart prescaler |
| freq_evt | input | 1 | Frequency-change event level; rising edge triggers |
| sts_clr | input | 1 | Clear strobe for the timeout status |
| sts_timeout | output | 1 | Sticky timeout status |
| rst_pulse | output | 1 | Reset pulse output |

## Verification
The bench measures the exact cycle at which status rises, at the smallest and largest field values on both bases. This catches a design that counts n units instead of n+1, or that uses the wrong base. It kicks the watchdog mid-count and changes the base select mid-count. A design that failed to clear the prescaler, or that read the select continuously, would expire early or late. The bench also holds clear across the expiry edge, waits long after expiry, and sends a second frequency edge during a pulse. A wrong clear/set priority would lose the status, a counter that wraps would fire again, and a retriggered pulse would come out longer than `RST_PULSE_CYC`.

// File: rtl/wdg_pkg.sv
// Package: shared types and helpers for the dual-scale watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdg_pkg;

    // Time-base selection encoding (0 = short unit, 1 = long unit)
    typedef enum logic {
        BASE_SHORT = 1'b0,
        BASE_LONG  = 1'b1
    } base_e;

    // Width able to hold values 0..v
    function automatic int unsigned bits_for(input int unsigned v);
        int unsigned w;
        w = 1;
        while ((1 << w) <= v) w++;
        return w;
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
// Module: wdg_prescaler
// Divides the clock into one tick per time unit. The unit length is
// SHORT_CYC or LONG_CYC cycles, chosen by a select latched at restart.
// Assumes: SHORT_CYC >= 1 and LONG_CYC >= 1. Restart takes priority over
// counting. Counting only advances while run is high.
module wdg_prescaler
    import wdg_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 15,
    parameter int unsigned LONG_CYC  = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic base_sel,
    input  logic run,
    output logic tick
);
    localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned PW      = bits_for(MAX_CYC);
    localparam logic [PW-1:0] SHORT_LAST = PW'(SHORT_CYC - 1);
    localparam logic [PW-1:0] LONG_LAST  = PW'(LONG_CYC - 1);

    base_e         base_q;
    logic [PW-1:0] div_q;
    logic [PW-1:0] last;

    // Terminal count of the selected unit
    always_comb begin
        last = (base_q == BASE_LONG) ? LONG_LAST : SHORT_LAST;
    end

    // Tick when the divider wraps during a run cycle without restart
    always_comb begin
        tick = run && !restart && (div_q == last);
    end

    // Latch the base select at restart
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= BASE_SHORT;
        else if (restart) base_q <= base_e'(base_sel);
    end

    // Divider counter: cleared at restart, wraps at the unit length
    always_ff @(posedge clk) begin
        if (!rst_n)                div_q <= '0;
        else if (restart)          div_q <= '0;
        else if (run) begin
            if (div_q == last)     div_q <= '0;
            else                   div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_counter.sv
// Module: wdg_counter
// Unit down-counter. A load arms it with the field value. Each tick then
// decrements it, and the tick that finds zero signals expiry and stops it.
// Assumes: tick is never high together with load (the prescaler
// suppresses it). Value n expires on the (n+1)th tick.
module wdg_counter #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          running,
    output logic          expire
);
    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Expiry when a tick lands on a zero count while armed
    always_comb begin
        expire = run_q && tick && !load && (cnt_q == '0);
    end

    assign running = run_q;

    // Armed flag: set by load, cleared at expiry
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (load)   run_q <= 1'b1;
        else if (expire) run_q <= 1'b0;
    end

    // Count register: load or decrement, holding at zero
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (load)                        cnt_q <= load_val;
        else if (run_q && tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/wdg_pulse.sv
// Module: wdg_pulse
// Fixed-length pulse generator. A trigger while idle starts a pulse of
// PULSE_CYC cycles. Triggers while a pulse is high are dropped.
// Assumes: PULSE_CYC >= 1.
module wdg_pulse
    import wdg_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int unsigned LW = bits_for(PULSE_CYC);
    localparam logic [LW-1:0] LEN = LW'(PULSE_CYC);

    logic [LW-1:0] left_q;

    assign pulse = (left_q != '0);

    // Remaining-cycle counter; starts only from idle
    always_ff @(posedge clk) begin
        if (!rst_n)                    left_q <= '0;
        else if (left_q != '0)         left_q <= left_q - 1'b1;
        else if (trig)                 left_q <= LEN;
    end

endmodule

// File: rtl/wdg_top.sv
// Module: wdg_top
// Dual-scale watchdog with reset generation. It combines the prescaler,
// the unit counter and the pulse generator. It also holds the sticky
// status and the frequency-change edge detector.
// Assumes: all inputs are synchronous to clk. reload covers both a
// timeout register write and a kick.
module wdg_top #(
    parameter int unsigned SHORT_CYC     = 15,
    parameter int unsigned LONG_CYC      = 250,
    parameter int unsigned RST_PULSE_CYC = 4,
    parameter int unsigned TO_W          = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TO_W-1:0] cfg_timeout,
    input  logic            cfg_long_base,
    input  logic            cfg_wd_rst_en,
    input  logic            cfg_fc_rst_en,
    input  logic            reload,
    input  logic            freq_evt,
    input  logic            sts_clr,
    output logic            sts_timeout,
    output logic            rst_pulse
);
    logic unit_tick;
    logic wd_running;
    logic wd_expire;
    logic evt_q;
    logic fc_req;
    logic pulse_trig;
    logic sts_q;

    wdg_prescaler #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (reload),
        .base_sel (cfg_long_base),
        .run      (wd_running),
        .tick     (unit_tick)
    );

    wdg_counter #(
        .CW (TO_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (cfg_timeout),
        .tick     (unit_tick),
        .running  (wd_running),
        .expire   (wd_expire)
    );

    // Frequency-event history for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= freq_evt;
    end

    // One-cycle delayed, enabled frequency-change request
    always_ff @(posedge clk) begin
        if (!rst_n) fc_req <= 1'b0;
        else        fc_req <= freq_evt && !evt_q && cfg_fc_rst_en;
    end

    // Merge the two reset sources
    always_comb begin
        pulse_trig = (wd_expire && cfg_wd_rst_en) || fc_req;
    end

    wdg_pulse #(
        .PULSE_CYC (RST_PULSE_CYC)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (pulse_trig),
        .pulse (rst_pulse)
    );

    // Sticky status: set on expiry (wins over clear), cleared by strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         sts_q <= 1'b0;
        else if (wd_expire) sts_q <= 1'b1;
        else if (sts_clr)   sts_q <= 1'b0;
    end

    assign sts_timeout = sts_q;

endmodule

// File: rtl/wdg_sva.sv
// Module: wdg_sva
// Property checker for wdg_top, attached by bind. It observes the ports
// and the internal expiry and frequency-request strobes.
// Assumes: RST_PULSE_CYC >= 2 for the frequency-change latency check.
module wdg_sva #(
    parameter int unsigned RST_PULSE_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_wd_rst_en,
    input logic cfg_fc_rst_en,
    input logic freq_evt,
    input logic sts_clr,
    input logic sts_timeout,
    input logic rst_pulse,
    input logic wd_expire,
    input logic fc_req
);
    logic [7:0] hi_len;

    // Length of the current high run of the reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_len <= '0;
        else if (rst_pulse) hi_len <= (hi_len == 8'hFF) ? hi_len : hi_len + 1'b1;
        else                hi_len <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $past(!rst_n) |-> !sts_timeout && !rst_pulse); // R1
    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n) wd_expire |=> sts_timeout); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) sts_timeout && !sts_clr |=> sts_timeout); // R4
    AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n) sts_clr && !wd_expire |=> !sts_timeout); // R4
    AST_WD_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n) wd_expire && cfg_wd_rst_en |=> rst_pulse); // R5
    AST_WD_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n) wd_expire && !cfg_wd_rst_en && !fc_req && !rst_pulse |=> !rst_pulse); // R5
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n) hi_len <= 8'(RST_PULSE_CYC)); // R6
    AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n) $fell(rst_pulse) |-> hi_len == 8'(RST_PULSE_CYC)); // R6
    AST_FC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) $rose(freq_evt) && cfg_fc_rst_en && !rst_pulse && !wd_expire && !fc_req |=> ##1 rst_pulse); // R7

endmodule

bind wdg_top wdg_sva #(
    .RST_PULSE_CYC (RST_PULSE_CYC)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wd_rst_en (cfg_wd_rst_en),
    .cfg_fc_rst_en (cfg_fc_rst_en),
    .freq_evt      (freq_evt),
    .sts_clr       (sts_clr),
    .sts_timeout   (sts_timeout),
    .rst_pulse     (rst_pulse),
    .wd_expire     (wd_expire),
    .fc_req        (fc_req)
);

// File: tb/tb_wdg_top.sv
// Bench for wdg_top: a table-driven sweep of timeouts, then directed tests.
module tb_wdg_top;
    localparam int SC = 3;
    localparam int LC = 7;
    localparam int PC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_timeout = '0;
    logic       cfg_long_base = 1'b0;
    logic       cfg_wd_rst_en = 1'b0;
    logic       cfg_fc_rst_en = 1'b0;
    logic       reload = 1'b0;
    logic       freq_evt = 1'b0;
    logic       sts_clr = 1'b0;
    logic       sts_timeout;
    logic       rst_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wdg_top #(
        .SHORT_CYC     (SC),
        .LONG_CYC      (LC),
        .RST_PULSE_CYC (PC),
        .TO_W          (5)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_timeout   (cfg_timeout),
        .cfg_long_base (cfg_long_base),
        .cfg_wd_rst_en (cfg_wd_rst_en),
        .cfg_fc_rst_en (cfg_fc_rst_en),
        .reload        (reload),
        .freq_evt      (freq_evt),
        .sts_clr       (sts_clr),
        .sts_timeout   (sts_timeout),
        .rst_pulse     (rst_pulse)
    );

    // Vector fields: {timeout[4:0], long_base, wd_en, expected cycles[8:0]}
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{
        {5'd0,  1'b0, 1'b1, 9'd3},
        {5'd31, 1'b0, 1'b0, 9'd96},
        {5'd5,  1'b1, 1'b1, 9'd42},
        {5'd31, 1'b1, 1'b1, 9'd224},
        {5'd2,  1'b0, 1'b0, 9'd9},
        {5'd0,  1'b1, 1'b0, 9'd7}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse reload for one edge, then count edges until status is seen
    task automatic arm_and_wait(output int k);
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
        k = 0;
        while (!sts_timeout && k < 400) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic clear_status();
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        int p;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(sts_timeout == 1'b0, "R1 status at reset", int'(sts_timeout), 0);
        check(rst_pulse == 1'b0, "R1 pulse at reset", int'(rst_pulse), 0);
        repeat (50) @(negedge clk);
        check(sts_timeout == 1'b0, "R1 no timeout before reload", int'(sts_timeout), 0);

        // R2 / R5 / R6: table sweep
        for (int i = 0; i < NV; i++) begin
            clear_status();
            cfg_timeout   = VEC[i][15:11];
            cfg_long_base = VEC[i][10];
            cfg_wd_rst_en = VEC[i][9];
            arm_and_wait(k);
            check(k == int'(VEC[i][8:0]), "R2 timeout length", k, int'(VEC[i][8:0]));
            check(rst_pulse == VEC[i][9], "R5 pulse at expiry", int'(rst_pulse), int'(VEC[i][9]));
            p = 0;
            while (rst_pulse && p < 20) begin
                p++;
                @(negedge clk);
            end
            check(p == (VEC[i][9] ? PC : 0), "R6 pulse length", p, VEC[i][9] ? PC : 0);
        end

        // R3 / R4: sticky status, no re-fire after expiry
        cfg_wd_rst_en = 1'b1;
        repeat (60) @(negedge clk);
        check(sts_timeout == 1'b1, "R4 status sticky", int'(sts_timeout), 1);
        check(rst_pulse == 1'b0, "R3 no second pulse", int'(rst_pulse), 0);
        clear_status();
        check(sts_timeout == 1'b0, "R4 clear", int'(sts_timeout), 0);
        repeat (300) @(negedge clk);
        check(sts_timeout == 1'b0, "R3 counter halted", int'(sts_timeout), 0);
        cfg_wd_rst_en = 1'b0;

        // R8: kick mid-count restarts the full period
        cfg_timeout = 5'd3;
        cfg_long_base = 1'b0;
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
        repeat (8) @(negedge clk);
        check(sts_timeout == 1'b0, "R8 no expiry before kick", int'(sts_timeout), 0);
        arm_and_wait(k);
        check(k == 12, "R8 period after kick", k, 12);
        clear_status();

        // R9: base select changed mid-count is ignored
        cfg_timeout = 5'd2;
        cfg_long_base = 1'b0;
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
        cfg_long_base = 1'b1;
        k = 0;
        while (!sts_timeout && k < 400) begin
            @(negedge clk);
            k++;
        end
        check(k == 9, "R9 base latched at reload", k, 9);
        cfg_long_base = 1'b0;
        clear_status();

        // R4: expiry wins over a clear on the same edge
        cfg_timeout = 5'd0;
        sts_clr = 1'b1;
        arm_and_wait(k);
        check(k == 3, "R4 set wins over clear", k, 3);
        @(negedge clk);
        check(sts_timeout == 1'b0, "R4 clear after set", int'(sts_timeout), 0);
        sts_clr = 1'b0;
        repeat (3) @(negedge clk);

        // R7: frequency-change pulse latency and length
        cfg_fc_rst_en = 1'b1;
        freq_evt = 1'b1;
        @(negedge clk);
        check(rst_pulse == 1'b0, "R7 no pulse at first edge", int'(rst_pulse), 0);
        @(negedge clk);
        check(rst_pulse == 1'b1, "R7 pulse at second edge", int'(rst_pulse), 1);
        p = 0;
        while (rst_pulse && p < 20) begin
            p++;
            @(negedge clk);
        end
        check(p == PC, "R6 fc pulse length", p, PC);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            hi += int'(rst_pulse);
        end
        check(hi == 0, "R7 held level no repeat", hi, 0);
        freq_evt = 1'b0;
        @(negedge clk);

        // R7: disabled frequency-change reset
        cfg_fc_rst_en = 1'b0;
        freq_evt = 1'b1;
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            hi += int'(rst_pulse);
        end
        check(hi == 0, "R7 disabled no pulse", hi, 0);
        freq_evt = 1'b0;
        @(negedge clk);

        // R6: second trigger during a pulse does not extend it
        cfg_fc_rst_en = 1'b1;
        freq_evt = 1'b1;
        hi = 0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            hi += int'(rst_pulse);
            if (i == 2) freq_evt = 1'b0;
            if (i == 3) freq_evt = 1'b1;
        end
        check(hi == PC, "R6 no restart on retrigger", hi, PC);
        freq_evt = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule